// File: doc/BRIEF.md
# Fifteen-Cent Coin Credit Controller

This block is a small synchronous state machine that sits behind a coin acceptor. It adds up nickels and dimes toward a fixed price of 15 cents. When the price is reached, it raises a single dispense line. The acceptor delivers each coin as a one-cycle pulse on its own sensor line. Pennies and quarters never reach the block, and no change is paid out. Any credit above the price is simply kept.

Credit is held in four flip-flops, one for each credit level (0, 5, 10 and 15 cents), with exactly one of them set. The next-state equations are read straight off the transition arcs. The dispense output is the 15-cent flip-flop itself, so it is glitch-free and has no logic after the register. After the price is reached, the machine holds the dispense state until a synchronous, active-high reset returns it to zero credit. Any register value that is not one-hot also falls back to zero credit on the next edge.

Top module: `coin_credit_fsm`

## Requirements
- R1: A synchronous active-high reset puts the machine at zero credit with dispense low on the following edge, whatever the coin inputs are in that cycle.
- R2: From zero credit, a nickel moves the credit to 5 cents and a dime moves it to 10 cents. Dispense stays low in both cases.
- R3: From 5 cents, a nickel moves the credit to 10 cents and a dime moves it to 15 cents.
- R4: From 10 cents, either coin moves the credit to 15 cents. The excess is absorbed and no change is given.
- R5: A cycle with neither coin input high leaves the credit unchanged.
- R6: A cycle with both coin inputs high is ignored, and the credit stays where it was.
- R7: Dispense is high exactly when the credit is 15 cents. It rises on the clock edge that samples the completing coin.
- R8: Once reached, the 15-cent state holds against any coin input until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero credit |
| nickel | input | 1 | One-cycle pulse for an accepted 5-cent coin |
| dime | input | 1 | One-cycle pulse for an accepted 10-cent coin |
| dispense | output | 1 | Registered release request, high while the price is met |

## Verification
The block has no parameters, so the bench builds its single fixed configuration. In that configuration every credit level and every arc out of it can be reached within three coins of a reset. Intermediate credit cannot be seen at the ports, so the bench tells 5 cents from 10 cents by the coin that follows: a second nickel must dispense only from 10 cents. The bench applies double-coin cycles and reset with a coin present in the same way, and then probes the credit with a follow-up coin.

// File: rtl/coin_credit_fsm.sv
module coin_credit_fsm (
  input  logic clk,
  input  logic rst,
  input  logic nickel,
  input  logic dime,
  output logic dispense
);

  localparam int NST = 4;
  localparam logic [NST-1:0] ZERO = 4'b0001;

  logic [NST-1:0] q, q_nx;
  logic n_only, d_only, idle;

  assign n_only = nickel & ~dime;
  assign d_only = dime & ~nickel;
  assign idle   = ~(n_only | d_only);

  always_comb begin
    q_nx[0] = q[0] & idle;
    q_nx[1] = (q[0] & n_only) | (q[1] & idle);
    q_nx[2] = (q[0] & d_only) | (q[1] & n_only) | (q[2] & idle);
    q_nx[3] = (q[1] & d_only) | (q[2] & (n_only | d_only)) | q[3];
    if (!$onehot(q)) q_nx = ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= ZERO;
    else     q <= q_nx;
  end

  assign dispense = q[3];

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (q == ZERO && !dispense));

  // R2
  zero_dime_chk: assert property (@(posedge clk) disable iff (rst)
    (q[0] && dime && !nickel) |=> q[2]);

  // R3
  five_dime_chk: assert property (@(posedge clk) disable iff (rst)
    (q[1] && dime && !nickel) |=> dispense);

  // R4
  ten_coin_chk: assert property (@(posedge clk) disable iff (rst)
    (q[2] && (nickel ^ dime)) |=> dispense);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!nickel && !dime && $onehot(q)) |=> $stable(q));

  // R6
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nickel && dime && $onehot(q)) |=> $stable(q));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    dispense |=> dispense);

endmodule

// File: tb/coin_credit_fsm_test.sv
`timescale 1ns/1ps
module coin_credit_fsm_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel = 1'b0;
  logic dime = 1'b0;
  logic dispense;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  coin_credit_fsm uut (
    .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .dispense(dispense)
  );

  localparam int NV = 30;
  // fields: rst, nickel, dime, expected dispense, requirement number
  localparam logic [7:0] VEC [0:NV-1] = '{
    8'b1_0_0_0_0001, // R1 reset
    8'b0_1_0_0_0010, // R2 nickel -> 5
    8'b0_1_0_0_0011, // R3 nickel -> 10
    8'b0_1_0_1_0100, // R4 nickel -> 15
    8'b1_0_0_0_0001, // R1
    8'b0_0_1_0_0010, // R2 dime -> 10
    8'b0_0_1_1_0100, // R4 dime from 10 absorbed
    8'b1_0_0_0_0001, // R1
    8'b0_1_0_0_0010, // R2 -> 5
    8'b0_0_1_1_0011, // R3 dime from 5 -> 15
    8'b1_0_0_0_0001, // R1
    8'b0_1_0_0_0010, // R2 -> 5
    8'b0_0_0_0_0101, // R5 hold
    8'b0_0_0_0_0101, // R5 hold
    8'b0_1_0_0_0011, // R3 -> 10
    8'b0_0_0_0_0101, // R5 hold at 10
    8'b0_1_0_1_0111, // R7 completing nickel
    8'b0_0_0_1_1000, // R8 idle held
    8'b0_1_0_1_1000, // R8 nickel held
    8'b0_0_1_1_1000, // R8 dime held
    8'b0_1_1_1_1000, // R8 both held
    8'b1_0_0_0_0001, // R1 clears
    8'b0_1_1_0_0110, // R6 both ignored at 0
    8'b0_1_1_0_0110, // R6 both ignored at 0
    8'b0_1_0_0_0010, // R2 -> 5 (proves still 0)
    8'b0_1_0_0_0011, // R3 -> 10 (proves was 5)
    8'b0_1_1_0_0110, // R6 both ignored at 10
    8'b0_0_1_1_0100, // R4 dime -> 15
    8'b1_1_0_0_0001, // R1 reset wins over nickel
    8'b0_0_0_0_0101  // R5 stays at 0
  };

  task automatic step(input logic r, input logic n, input logic d,
                      input logic exp, input int req);
    rst = r; nickel = n; dime = d;
    @(posedge clk);
    #1;
    checks++;
    if (dispense !== exp) begin
      fails++;
      $display("FAIL R%0d dispense=%b expected=%b", req, dispense, exp);
    end
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < NV; i++)
      step(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
    // R1 reset mid-credit with a dime present, then probe with coins
    step(1'b0, 1'b1, 1'b0, 1'b0, 2);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1);
    step(1'b0, 1'b0, 1'b1, 1'b0, 2);
    step(1'b0, 1'b1, 1'b0, 1'b1, 4);
    // R6 both ignored at 5: next nickel must not dispense
    step(1'b1, 1'b0, 1'b0, 1'b0, 1);
    step(1'b0, 1'b1, 1'b0, 1'b0, 2);
    step(1'b0, 1'b1, 1'b1, 1'b0, 6);
    step(1'b0, 1'b1, 1'b0, 1'b0, 3);
    step(1'b0, 1'b1, 1'b0, 1'b1, 4);
    // R7 dispense low before the completing edge, high after
    step(1'b1, 1'b0, 1'b0, 1'b0, 1);
    step(1'b0, 1'b0, 1'b1, 1'b0, 7);
    rst = 1'b0; nickel = 1'b1; dime = 1'b0;
    #1;
    checks++;
    if (dispense !== 1'b0) begin
      fails++;
      $display("FAIL R7 dispense=%b expected=0 before edge", dispense);
    end
    @(negedge clk);
    nickel = 1'b0;
    checks++;
    if (dispense !== 1'b1) begin
      fails++;
      $display("FAIL R7 dispense=%b expected=1 after edge", dispense);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired dispense=%b expected=completion", dispense);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule